// File: doc/BRIEF.md
# Quadrature Position Decoder with Count and Cascade Events

This block turns two quadrature channels, A and B, into position counts at four counts per full encoder cycle. Each legal change on either channel moves an internal up/down counter by one, and the new value is available on a parallel output. The inputs must already be synchronized to the clock and free of glitches.

Each count is also reported on pins, so that other logic can follow the motion without reading the counter. A count pulse lasts half a clock cycle and falls in the low phase of the cycle in which the counter takes its new value. A direction level appears one clock before that cycle and stays valid through it. A separate cascade pulse, timed the same way, marks each wrap of the counter so that a further counter can extend the range. If both channels change in the same cycle, the block does not count and raises an error flag for one cycle.

Top module: `qdec_4x`

## Requirements
- R1: Channel values are written as (A,B). The sequence 00, 10, 11, 01, 00 counts up (A leads B) and the reverse order counts down. Each single-channel change moves `count_val` by exactly one, modulo 2^W.
- R2: After an input change, `count_val` takes its new value at the second rising clock edge, and not before.
- R3: `cnt_pulse` is high only in the low phase of the clock cycle that starts at the edge where `count_val` is updated. It is low in the high phase of that cycle and low in every cycle with no count.
- R4: `dir_up` (1 = up) takes the direction of a count at the first rising edge after the input change, one cycle ahead of the pulse cycle. It holds that value through the pulse and until a later count changes it, provided counts are at least two cycles apart.
- R5: A count up from all ones to zero raises `cas_pulse` in the low phase of the same cycle as `cnt_pulse`.
- R6: A count down from zero to all ones raises `cas_pulse` in the same way. No count that does not wrap raises `cas_pulse`.
- R7: A change of both channels in one cycle is illegal. It does not change `count_val`, `cnt_pulse`, `cas_pulse` or `dir_up`, and it sets `err` high for exactly the cycle after the first rising edge after the change.
- R8: While both channels stay unchanged, `count_val`, `dir_up` and `err` do not change, and neither pulse occurs.
- R9: Reset is synchronous and active low. It clears `count_val`, `dir_up`, `err` and both pulses. The channel values present during reset become the reference, so releasing reset causes no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its low phase also times the pulses |
| rst_n | input | 1 | Synchronous active-low reset |
| qa | input | 1 | Quadrature channel A, already synchronized |
| qb | input | 1 | Quadrature channel B, already synchronized |
| count_val | output | W | Current position count |
| cnt_pulse | output | 1 | Half-cycle pulse, one per count |
| cas_pulse | output | 1 | Half-cycle pulse, one per counter wrap |
| dir_up | output | 1 | Direction of the latest count, 1 = up |
| err | output | 1 | One-cycle flag for an illegal double change |

## Verification
On every cycle the assertions check four things: the counter moves by at most one step, each registered event changes the counter, the direction agrees with the sign of each step, and a cascade event coincides with a count and lands on zero or all ones as the direction requires. They also check that an illegal change leaves the counter alone. The bench scenarios are the only check of the exact cycle in which the count appears and the half-cycle placement of both pulses. The same holds for the direction setup one cycle ahead and the neglect of channel values present at reset release. The bench drives long up and down runs that wrap a 4-bit counter several times, illegal double changes from every phase, idle periods and a reset in mid-run.

// File: rtl/qdec_pkg.sv
// Shared types and helpers for the quadrature decoder.
// Assumes channel values are synchronous to the decoder clock.
package qdec_pkg;

    // Phase difference between two samples, modulo four
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_FWD  = 2'd1,
        STEP_BAD  = 2'd2,
        STEP_REV  = 2'd3
    } step_e;

    // Map (A,B) onto a 0..3 position along the up sequence 00,10,11,01
    function automatic logic [1:0] phase_of(input logic a, input logic b);
        return {b, a ^ b};
    endfunction

    // Classify the move from an old phase to a new one
    function automatic step_e classify(input logic [1:0] old_ph, input logic [1:0] new_ph);
        logic [1:0] diff;
        diff = new_ph - old_ph;
        return step_e'(diff);
    endfunction

endpackage

// File: rtl/qdec_phase_decoder.sv
// Stage 1 of the decoder: compares the channels with the last sample and
// registers one event flag, the direction level and the illegal-change flag.
// Assumes qa/qb are synchronized; reset loads the live phase as reference.
module qdec_phase_decoder
    import qdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_in,
    input  logic b_in,
    output logic ev_o,
    output logic dir_o,
    output logic err_o
);

    logic [1:0] prev_ph;
    logic [1:0] cur_ph;
    step_e      step;

    // Current phase and its relation to the stored one
    always_comb begin
        cur_ph = phase_of(a_in, b_in);
        step   = classify(prev_ph, cur_ph);
    end

    // Sample the phase and register the decoded event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ph <= cur_ph;
            ev_o    <= 1'b0;
            dir_o   <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            prev_ph <= cur_ph;
            ev_o    <= (step == STEP_FWD) || (step == STEP_REV);
            err_o   <= (step == STEP_BAD);
            if (step == STEP_FWD) begin
                dir_o <= 1'b1;
            end else if (step == STEP_REV) begin
                dir_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/qdec_updown_counter.sv
// Stage 2 of the decoder: applies a registered event to the W-bit counter
// and registers the event and wrap flags aligned with the new count.
// Assumes ev_i and up_i come from stage 1 in the same cycle.
module qdec_updown_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_i,
    input  logic         up_i,
    output logic [W-1:0] count_o,
    output logic         ev_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE_VAL = {{(W-1){1'b0}}, 1'b1};

    logic at_edge;

    // Detect whether the pending step leaves the counter range
    always_comb begin
        at_edge = up_i ? (count_o == TOP_VAL) : (count_o == '0);
    end

    // Update the counter and align the event flags with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            ev_o    <= 1'b0;
            wrap_o  <= 1'b0;
        end else begin
            ev_o   <= ev_i;
            wrap_o <= ev_i && at_edge;
            if (ev_i) begin
                count_o <= up_i ? (count_o + ONE_VAL) : (count_o - ONE_VAL);
            end
        end
    end

endmodule

// File: rtl/qdec_pulse_gen.sv
// Turns registered event flags into pulses confined to the low clock phase.
// Assumes each flag is registered on the rising edge and held one cycle.
module qdec_pulse_gen #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] flag_i,
    output logic [N-1:0] pulse_o
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_lane
            // Gate each flag with the inverted clock
            assign pulse_o[gi] = flag_i[gi] & ~clk;
        end
    endgenerate

endmodule

// File: rtl/qdec_4x.sv
// Four-count-per-cycle quadrature decoder with count and cascade event pins.
// Pipeline: stage 1 decodes and presents direction; stage 2 updates the
// counter; the pulses then fall in the low phase of the stage-2 cycle.
// Assumes qa/qb are synchronized and counts come at least two cycles apart.
module qdec_4x #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         qa,
    input  logic         qb,
    output logic [W-1:0] count_val,
    output logic         cnt_pulse,
    output logic         cas_pulse,
    output logic         dir_up,
    output logic         err
);

    localparam int NPULSE = 2;

    logic              ev_s1;
    logic              ev_s2;
    logic              cas_s2;
    logic [NPULSE-1:0] pulses;

    qdec_phase_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (qa),
        .b_in  (qb),
        .ev_o  (ev_s1),
        .dir_o (dir_up),
        .err_o (err)
    );

    qdec_updown_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev_s1),
        .up_i    (dir_up),
        .count_o (count_val),
        .ev_o    (ev_s2),
        .wrap_o  (cas_s2)
    );

    qdec_pulse_gen #(.N(NPULSE)) u_pulse (
        .clk     (clk),
        .flag_i  ({cas_s2, ev_s2}),
        .pulse_o (pulses)
    );

    assign cnt_pulse = pulses[0];
    assign cas_pulse = pulses[1];

endmodule

// File: rtl/qdec_4x_chk.sv
// Property checker for qdec_4x, attached through bind.
// Assumes counts at least two cycles apart and W of two or more.
module qdec_4x_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] count_val,
    input logic         dir_up,
    input logic         err,
    input logic         ev_s2,
    input logic         cas_s2
);

    localparam logic [W-1:0] ONE_VAL = {{(W-1){1'b0}}, 1'b1};

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_val != $past(count_val)) |->
        ((count_val == $past(count_val) + ONE_VAL) || (count_val == $past(count_val) - ONE_VAL))); // R1

    AST_EVENT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_s2 |-> (count_val != $past(count_val))); // R3

    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_val != $past(count_val)) && $stable(dir_up)) |->
        (dir_up == (count_val == $past(count_val) + ONE_VAL))); // R4

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_s2 && dir_up && $stable(dir_up)) |-> (count_val == '0)); // R5

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_s2 && !dir_up && $stable(dir_up)) |-> (count_val == {W{1'b1}})); // R6

    AST_WRAP_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        cas_s2 |-> ev_s2); // R6

    AST_ERR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(count_val)); // R7

endmodule

bind qdec_4x qdec_4x_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_val (count_val),
    .dir_up    (dir_up),
    .err       (err),
    .ev_s2     (ev_s2),
    .cas_s2    (cas_s2)
);

// File: tb/qdec_4x_tb.sv
module qdec_4x_tb;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         qa = 1'b1;
    logic         qb = 1'b1;
    logic [W-1:0] count_val;
    logic         cnt_pulse;
    logic         cas_pulse;
    logic         dir_up;
    logic         err;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    int exp_dir = 0;
    int pos = 2;
    bit done = 0;

    qdec_4x #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .qa        (qa),
        .qb        (qb),
        .count_val (count_val),
        .cnt_pulse (cnt_pulse),
        .cas_pulse (cas_pulse),
        .dir_up    (dir_up),
        .err       (err)
    );

    always #10 clk = ~clk;

    // (A,B) at position p of the up sequence 00,10,11,01
    function automatic logic [1:0] ab_at(input int p);
        case (p & 3)
            0:       return 2'b00;
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one input change and follow it through the pipeline
    // kind: 0 = none, 1 = up, -1 = down, 2 = illegal
    task automatic step(input int kind);
        int  nxt;
        bit  ev;
        bit  wrap;
        logic [1:0] ab;
        ev   = (kind == 1) || (kind == -1);
        wrap = (kind == 1 && exp_cnt == MASK) || (kind == -1 && exp_cnt == 0);
        if (kind == 2) pos = pos + 2;
        else pos = pos + kind;
        ab = ab_at(pos);
        nxt = ev ? ((exp_cnt + kind) & MASK) : exp_cnt;
        if (kind == 1) exp_dir = 1;
        if (kind == -1) exp_dir = 0;
        @(negedge clk);
        qa = ab[1];
        qb = ab[0];
        @(posedge clk); #2;
        chk("R4 dir set one cycle ahead", int'(dir_up), exp_dir);
        chk(kind == 2 ? "R7 err raised" : "R8 err quiet", int'(err), kind == 2 ? 1 : 0);
        chk("R2 count not yet updated", int'(count_val), exp_cnt);
        @(posedge clk); #2;
        exp_cnt = nxt;
        chk(ev ? "R1 count step" : (kind == 2 ? "R7 count kept" : "R8 count kept"),
            int'(count_val), exp_cnt);
        chk("R3 pulse low in high phase", int'(cnt_pulse), 0);
        chk("R7 err one cycle", int'(err), 0);
        @(negedge clk); #2;
        chk(ev ? "R3 pulse in low phase" : "R8 no pulse", int'(cnt_pulse), ev ? 1 : 0);
        chk(kind == -1 ? "R6 cascade" : "R5 cascade", int'(cas_pulse), wrap ? 1 : 0);
        chk("R4 dir held through pulse", int'(dir_up), exp_dir);
    endtask

    task automatic reset_check(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk({tag, " R9 count cleared"}, int'(count_val), 0);
        chk({tag, " R9 dir cleared"}, int'(dir_up), 0);
        chk({tag, " R9 err cleared"}, int'(err), 0);
        @(negedge clk); #2;
        chk({tag, " R9 no pulses"}, int'(cnt_pulse | cas_pulse), 0);
        rst_n = 1'b1;
        exp_cnt = 0;
        exp_dir = 0;
        repeat (3) @(posedge clk);
        #2;
        chk({tag, " R9 no count on release"}, int'(count_val), 0);
        chk({tag, " R9 dir after release"}, int'(dir_up), 0);
    endtask

    initial begin
        // Hold channels at 11 through reset: must become the reference
        reset_check("initial");
        for (int i = 0; i < 3 * (MASK + 1) - 5; i++) step(1);
        for (int i = 0; i < 3 * (MASK + 1) + 3; i++) step(-1);
        for (int i = 0; i < 4; i++) begin
            step(2);
            step(1);
        end
        for (int i = 0; i < 6; i++) begin
            step(1);
            step(-1);
        end
        for (int i = 0; i < 5; i++) step(0);
        step(-1);
        step(0);
        step(1);
        // Channels now away from 00; reset in mid-run
        reset_check("midrun");
        for (int i = 0; i < MASK + 3; i++) step(1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule